// File: doc/BRIEF.md
# Single-to-Dual Port Pixel Demultiplexer

This block takes a video pixel stream that carries one RGB pixel per clock, 10 bits per colour, and turns it into a two-pixel stream. The two-pixel stream has one odd bus and one even bus, and each colour is 12 bits wide. Two consecutive active pixels are combined into one output beat. A single-cycle strobe marks each beat, so the output runs at half the input pixel rate, and data enable (DE) travels with each beat. A configuration input sets which bus receives the first pixel of every line. Changing that input only swaps the two buses. The beat timing stays the same.

A second configuration input puts the block in a pass-through mode. In that mode the source already delivers two pixels per clock. Both input ports are widened and registered straight to the odd and even buses, one beat every clock.

The control logic is a three-state machine:

- `S_IDLE` is the state between lines.
- `S_HALF` means one pixel of a pair is held.
- `S_LINE` means the block is inside a line with no pixel held.

The transitions are:

- idle→half when DE is high.
- half→line when a second pixel completes the pair.
- line→half when the next pixel arrives.
- half→idle when DE falls and the lone pixel is flushed.
- line→idle when DE falls.
- Any state goes to idle while pass-through mode is selected.

Top module: `pix_pair_demux`

## Requirements
- R1: While reset is asserted, and immediately after it, `out_stb` and `out_de` are 0 and both pixel buses are all zero.
- R2: In single-port mode, each pair of consecutive active pixels produces exactly one beat (`out_stb` high for one cycle, `out_de` high). The beat appears on the clock edge that samples the second pixel of the pair, and not on the edge that samples the first.
- R3: With `first_even`=0, the earlier pixel of each pair goes to `odd_pix` and the later one to `even_pix`. With `first_even`=1, the two are swapped. The strobe timing is the same in both cases.
- R4: Pairing restarts at every rising edge of `in_de`. The first active pixel of a line always lands on the bus selected by `first_even`, whatever the parity of the previous line, even after a one-cycle blanking gap.
- R5: If a line has an odd number of pixels, its last pixel is emitted on the edge where `in_de` is first sampled low. That pixel goes on the selected bus and the partner bus is all zero.
- R6: An input pixel is packed as red [29:20], green [19:10], blue [9:0]. An output pixel is packed as red [35:24], green [23:12], blue [11:0]. Each 10-bit colour sits in the upper bits of its 12-bit field, with the two LSBs zero, so the top 8 bits of each field equal the top 8 bits of the input colour.
- R7: In single-port mode, `out_stb` is never high on two consecutive cycles. While idle between lines, the block strobes every second cycle with `out_de`=0 and both buses zero.
- R8: In pass-through mode, every clock produces a beat one cycle later. `out_de` equals the sampled `in_de`, port A widened goes to `odd_pix`, port B widened goes to `even_pix`, and `first_even` has no effect.
- R9: In single-port mode, `in_pix_b` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 1: two-pixel pass-through, 0: single-port demultiplexing |
| first_even | input | 1 | 1: first pixel of a line goes to the even bus |
| in_de | input | 1 | Input data enable |
| in_pix_a | input | 30 | Pixel input A (the only pixel in single-port mode) |
| in_pix_b | input | 30 | Pixel input B (used in pass-through mode only) |
| out_stb | output | 1 | Beat strobe |
| out_de | output | 1 | Data enable of the beat |
| odd_pix | output | 36 | Odd-bus pixel, 12 bits per colour |
| even_pix | output | 36 | Even-bus pixel, 12 bits per colour |

## Verification
A wrong internal state shows up at the ports within one or two beats:

- A half-held pixel that is left stale after a line ends makes the first pair of the next line come out on the wrong bus, or shifted by one pixel.
- A lost held pixel shows up as a missing or zero-partnered beat one edge after DE falls.
- A blanking phase counter that sticks shows up as strobes on adjacent cycles, or as no strobes at all during the gap.

Every expected pair is derived from the pixel sequence that was driven and compared in arrival order, so any swap, drop or duplication is reported at the beat where it happens.

// File: rtl/pix_demux_pkg.sv
package pix_demux_pkg;

    // Pairing state of the demultiplexer
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,   // between lines, nothing held
        S_HALF = 2'd1,   // first pixel of a pair held
        S_LINE = 2'd2    // inside a line, pair just emitted
    } pair_state_e;

endpackage

// File: rtl/pix_widen.sv
module pix_widen #(
    parameter int CW_IN  = 10,
    parameter int CW_OUT = 12,
    parameter int NCH    = 3
) (
    input  logic [NCH*CW_IN-1:0]  px_in,
    output logic [NCH*CW_OUT-1:0] px_out
);
    localparam int PAD = CW_OUT - CW_IN;

    // Each colour is left-aligned in its wider field; LSBs zero-filled
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign px_out[c*CW_OUT +: CW_OUT] = {px_in[c*CW_IN +: CW_IN], {PAD{1'b0}}};
    end
endmodule

// File: rtl/pix_pair_fsm.sv
module pix_pair_fsm
    import pix_demux_pkg::*;
#(
    parameter int PW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual_mode,
    input  logic          first_even,
    input  logic          in_de,
    input  logic [PW-1:0] wide_a,
    input  logic [PW-1:0] wide_b,
    output logic          out_stb,
    output logic          out_de,
    output logic [PW-1:0] odd_pix,
    output logic [PW-1:0] even_pix
);
    pair_state_e   state, nxt;
    logic [PW-1:0] hold_q;
    logic          blank_tgl;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (dual_mode) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: nxt = in_de ? S_HALF : S_IDLE;
                S_HALF: nxt = in_de ? S_LINE : S_IDLE;
                S_LINE: nxt = in_de ? S_HALF : S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // Registered outputs and pair storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_stb   <= 1'b0;
            out_de    <= 1'b0;
            odd_pix   <= '0;
            even_pix  <= '0;
            hold_q    <= '0;
            blank_tgl <= 1'b0;
        end else if (dual_mode) begin
            out_stb   <= 1'b1;
            out_de    <= in_de;
            odd_pix   <= wide_a;
            even_pix  <= wide_b;
            blank_tgl <= 1'b0;
        end else begin
            out_stb <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (in_de) begin
                        hold_q    <= wide_a;
                        blank_tgl <= 1'b0;
                    end else begin
                        blank_tgl <= ~blank_tgl;
                        if (blank_tgl) begin
                            out_stb  <= 1'b1;
                            out_de   <= 1'b0;
                            odd_pix  <= '0;
                            even_pix <= '0;
                        end
                    end
                end
                S_HALF: begin
                    out_stb   <= 1'b1;
                    out_de    <= 1'b1;
                    blank_tgl <= 1'b0;
                    if (first_even) begin
                        even_pix <= hold_q;
                        odd_pix  <= in_de ? wide_a : '0;
                    end else begin
                        odd_pix  <= hold_q;
                        even_pix <= in_de ? wide_a : '0;
                    end
                end
                S_LINE: begin
                    blank_tgl <= 1'b0;
                    if (in_de) hold_q <= wide_a;
                end
                default: blank_tgl <= 1'b0;
            endcase
        end
    end

    // R7: no back-to-back strobes in single-port mode
    p_single_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && out_stb) |=> !out_stb)
        else $error("p_single_gap_r7");

    // R8: pass-through beat every clock, ports mapped A->odd, B->even
    p_dual_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dual_mode |=> (out_stb && out_de == $past(in_de)
                       && odd_pix == $past(wide_a) && even_pix == $past(wide_b)))
        else $error("p_dual_pass_r8");

    // R3: second pixel of a pair lands on the port opposite the first
    p_first_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && state == S_HALF && in_de) |=>
        (out_stb && out_de &&
         ($past(first_even) ? odd_pix == $past(wide_a) : even_pix == $past(wide_a))))
        else $error("p_first_port_r3");

    // R5: lone last pixel is paired with zero
    p_lone_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && state == S_HALF && !in_de) |=>
        (out_stb && out_de && ($past(first_even) ? odd_pix == '0 : even_pix == '0)))
        else $error("p_lone_zero_r5");

    // R4: a rising DE always starts a fresh pair
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && $rose(in_de)) |=> state == S_HALF)
        else $error("p_restart_r4");
endmodule

// File: rtl/pix_pair_demux.sv
module pix_pair_demux #(
    parameter int CW_IN  = 10,
    parameter int CW_OUT = 12,
    parameter int NCH    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dual_mode,
    input  logic                    first_even,
    input  logic                    in_de,
    input  logic [NCH*CW_IN-1:0]    in_pix_a,
    input  logic [NCH*CW_IN-1:0]    in_pix_b,
    output logic                    out_stb,
    output logic                    out_de,
    output logic [NCH*CW_OUT-1:0]   odd_pix,
    output logic [NCH*CW_OUT-1:0]   even_pix
);
    localparam int PW = NCH * CW_OUT;

    logic [PW-1:0] wide_a, wide_b;

    pix_widen #(.CW_IN(CW_IN), .CW_OUT(CW_OUT), .NCH(NCH)) u_widen_a (
        .px_in  (in_pix_a),
        .px_out (wide_a)
    );

    pix_widen #(.CW_IN(CW_IN), .CW_OUT(CW_OUT), .NCH(NCH)) u_widen_b (
        .px_in  (in_pix_b),
        .px_out (wide_b)
    );

    pix_pair_fsm #(.PW(PW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dual_mode  (dual_mode),
        .first_even (first_even),
        .in_de      (in_de),
        .wide_a     (wide_a),
        .wide_b     (wide_b),
        .out_stb    (out_stb),
        .out_de     (out_de),
        .odd_pix    (odd_pix),
        .even_pix   (even_pix)
    );
endmodule

// File: tb/pix_pair_demux_tb.sv
module pix_pair_demux_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dual_mode = 1'b0;
    logic        first_even = 1'b0;
    logic        in_de = 1'b0;
    logic [29:0] in_pix_a = '0;
    logic [29:0] in_pix_b = '0;
    logic        out_stb, out_de;
    logic [35:0] odd_pix, even_pix;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit prev_stb = 1'b0;

    logic [35:0] q_odd[$];
    logic [35:0] q_even[$];
    string       q_tag[$];

    always #10 clk = ~clk;  // 50 MHz

    pix_pair_demux u_dut (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .first_even(first_even),
        .in_de(in_de), .in_pix_a(in_pix_a), .in_pix_b(in_pix_b),
        .out_stb(out_stb), .out_de(out_de), .odd_pix(odd_pix), .even_pix(even_pix)
    );

    function automatic logic [29:0] mkpix(int s);
        logic [9:0] r, g, b;
        r = 10'(s * 97 + 13);
        g = 10'(s * 53 + 7);
        b = 10'(s * 29 + 400);
        return {r, g, b};
    endfunction

    function automatic logic [35:0] wid(logic [29:0] p);
        return {p[29:20], 2'b00, p[19:10], 2'b00, p[9:0], 2'b00};
    endfunction

    task automatic chk(bit ok, string req, logic [71:0] act, logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Beat monitor: compares data beats in arrival order, checks blank beats
    always @(posedge clk) begin
        #1;
        if (mon_on && rst_n) begin
            if (out_stb && prev_stb)
                chk(1'b0, "R7 consecutive strobes", 72'(out_stb), 72'(0));
            if (out_stb && out_de) begin
                if (q_odd.size() == 0) begin
                    chk(1'b0, "R2 unexpected beat", {odd_pix, even_pix}, 72'(0));
                end else begin
                    logic [35:0] eo, ee;
                    string tg;
                    eo = q_odd.pop_front();
                    ee = q_even.pop_front();
                    tg = q_tag.pop_front();
                    chk({odd_pix, even_pix} == {eo, ee}, tg, {odd_pix, even_pix}, {eo, ee});
                end
            end else if (out_stb && !out_de) begin
                chk({odd_pix, even_pix} == 72'(0), "R7 blank beat data", {odd_pix, even_pix}, 72'(0));
            end
            prev_stb = out_stb;
        end else begin
            prev_stb = 1'b0;
        end
    end

    // Drive one line of n pixels then gap blank cycles; queue expected pairs
    task automatic drive_line(int n, int seed, bit fe, int gap, bit b_ones, string tag);
        for (int k = 0; k < n; k += 2) begin
            logic [35:0] f, s;
            f = wid(mkpix(seed + k));
            s = (k + 1 < n) ? wid(mkpix(seed + k + 1)) : 36'(0);
            q_odd.push_back(fe ? s : f);
            q_even.push_back(fe ? f : s);
            q_tag.push_back(tag);
        end
        @(negedge clk);
        first_even = fe;
        for (int i = 0; i < n; i++) begin
            in_de = 1'b1;
            in_pix_a = mkpix(seed + i);
            in_pix_b = b_ones ? '1 : ~mkpix(seed + i);  // R9: port B must not matter
            @(negedge clk);
        end
        in_de = 1'b0;
        in_pix_a = '0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(out_stb == 0 && out_de == 0, "R1 reset ctrl", 72'({out_stb, out_de}), 72'(0));
        chk({odd_pix, even_pix} == 72'(0), "R1 reset data", {odd_pix, even_pix}, 72'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(out_stb == 0 && out_de == 0, "R1 after release", 72'({out_stb, out_de}), 72'(0));
    endtask

    // R2: strobe appears on the edge sampling the second pixel, not the first
    task automatic t_latency();
        logic [29:0] p0, p1;
        p0 = mkpix(900);
        p1 = mkpix(901);
        q_odd.push_back(wid(p0));
        q_even.push_back(wid(p1));
        q_tag.push_back("R2 latency pair");
        @(negedge clk);
        first_even = 1'b0;
        in_de = 1'b1;
        in_pix_a = p0;
        @(posedge clk);
        #1;
        chk(out_stb == 0, "R2 no beat on first pixel", 72'(out_stb), 72'(0));
        @(negedge clk);
        in_pix_a = p1;
        @(posedge clk);
        #1;
        chk(out_stb == 1 && out_de == 1, "R2 beat on second pixel", 72'({out_stb, out_de}), 72'(3));
        @(negedge clk);
        in_de = 1'b0;
        in_pix_a = '0;
        repeat (3) @(negedge clk);
    endtask

    // R6: field placement and 8-bit taps
    task automatic t_widen();
        logic [29:0] p;
        p = {10'h3A5, 10'h15C, 10'h2F3};
        @(negedge clk);
        first_even = 1'b0;
        in_de = 1'b1;
        in_pix_a = p;
        @(negedge clk);
        in_de = 1'b0;
        in_pix_a = '0;
        q_odd.push_back(36'h0);  // placeholder consumed below, monitor off
        q_odd.delete();
        mon_on = 1'b0;
        @(posedge clk);
        #1;
        chk(odd_pix == {12'hE94, 12'h570, 12'hBCC}, "R6 field placement", 72'(odd_pix),
            72'({12'hE94, 12'h570, 12'hBCC}));
        chk(odd_pix[35:28] == p[29:22] && odd_pix[23:16] == p[19:12] && odd_pix[11:4] == p[9:2],
            "R6 8-bit taps", 72'({odd_pix[35:28], odd_pix[23:16], odd_pix[11:4]}),
            72'({p[29:22], p[19:12], p[9:2]}));
        chk(even_pix == 36'h0, "R5 lone partner zero", 72'(even_pix), 72'(0));
        repeat (3) @(negedge clk);
        mon_on = 1'b1;
    endtask

    // R7: blanking cadence
    task automatic t_blank();
        int cnt;
        cnt = 0;
        @(negedge clk);
        in_de = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            #1;
            if (out_stb) cnt++;
            chk(out_de == 0, "R7 blank de low", 72'(out_de), 72'(0));
        end
        chk(cnt == 3, "R7 blank strobe count", 72'(cnt), 72'(3));
    endtask

    // R8: pass-through
    task automatic t_dual();
        logic [29:0] a, b;
        @(negedge clk);
        mon_on = 1'b0;
        dual_mode = 1'b1;
        first_even = 1'b1;  // R8: must have no effect
        for (int i = 0; i < 4; i++) begin
            a = mkpix(300 + i);
            b = mkpix(700 + i);
            in_de = (i != 2);
            in_pix_a = a;
            in_pix_b = b;
            @(posedge clk);
            #1;
            chk(out_stb == 1 && out_de == (i != 2), "R8 dual strobe/de",
                72'({out_stb, out_de}), 72'({1'b1, i != 2}));
            chk(odd_pix == wid(a) && even_pix == wid(b), "R8 dual mapping",
                {odd_pix, even_pix}, {wid(a), wid(b)});
            @(negedge clk);
        end
        dual_mode = 1'b0;
        in_de = 1'b0;
        in_pix_a = '0;
        in_pix_b = '0;
        @(posedge clk);
        #1;
        chk(out_stb == 0, "R7 no strobe after leaving dual", 72'(out_stb), 72'(0));
        @(negedge clk);
        mon_on = 1'b1;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_bad++;
                n_chk++;
                $display("FAIL watchdog expired");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        join_none

        t_reset();
        mon_on = 1'b1;
        t_latency();                                          // R2
        drive_line(8, 10, 1'b0, 4, 1'b0, "R3 odd-first pairs");
        drive_line(8, 40, 1'b1, 4, 1'b0, "R3 even-first pairs");
        drive_line(5, 70, 1'b0, 3, 1'b0, "R5 odd length odd-first");
        drive_line(7, 90, 1'b1, 3, 1'b0, "R5 odd length even-first");
        drive_line(3, 120, 1'b0, 1, 1'b0, "R4 restart after odd line");
        drive_line(2, 140, 1'b0, 1, 1'b0, "R4 restart fresh pair");
        drive_line(1, 160, 1'b1, 1, 1'b0, "R4 single-pixel line");
        drive_line(4, 170, 1'b1, 3, 1'b0, "R4 line after one-gap");
        drive_line(6, 200, 1'b0, 3, 1'b1, "R9 port B all ones ignored");
        t_widen();                                            // R6
        t_blank();                                            // R7
        t_dual();                                             // R8
        drive_line(4, 250, 1'b0, 4, 1'b0, "R8 single mode resumes");
        repeat (4) @(negedge clk);
        chk(q_odd.size() == 0, "R2 all expected beats seen", 72'(q_odd.size()), 72'(0));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule